// File: doc/BRIEF.md
# Variable-length ring pattern generator

This block produces stimulus for a circuit under test during built-in self-test while keeping switching activity low. Each seed comes with a mask that splits the output bits into two groups. Bits whose mask is set are "acting": they are chained into a short ring that rotates once per enabled clock. Bits whose mask is clear are "frozen": they keep their seed value for the whole run. Because the mask can change with every seed, the length of the ring changes from seed to seed. Only the acting bits toggle, so the circuit under test sees far fewer input transitions than with a full-width ring.

A controller loads a seed, a mask, a feedback mode and a run length in one cycle. It then raises the enable. The generator advances one rotation per enabled cycle until the programmed number of rotations has been applied. It then raises a done flag and holds the last pattern until the next load. Seed storage and response analysis sit outside the block.

Top module: `vl_ring_tpg`

## Requirements
- R1: While reset is held and after it is released with no load, `pattern_o` is all zeros and `done_o` is 0.
- R2: A cycle with `load_i`=1 makes `pattern_o` equal to `seed_i` after that clock edge and restarts the rotation count at zero. `done_o` after that edge is 1 only if `run_len_i` was 0.
- R3: Every bit whose mask bit is 0 keeps its seed value on every cycle until the next load.
- R4: With `twist_i`=0 and at least two acting bits, one rotation moves each acting bit to the next higher-indexed acting position. Frozen positions are skipped, and the highest acting bit moves unchanged to the lowest acting position.
- R5: With `twist_i`=1 and at least two acting bits, rotation is as in R4, except that the value wrapping from the highest to the lowest acting position is inverted.
- R6: A cycle with `enable_i`=0 and `load_i`=0 leaves `pattern_o` and the rotation count unchanged.
- R7: After exactly `run_len_i` enabled cycles since the load, `done_o` is 1. From then on the pattern holds and `done_o` stays 1 until the next load, even if `enable_i` stays 1.
- R8: If the mask has fewer than two bits set, `pattern_o` keeps the seed value in either mode. `done_o` still rises after `run_len_i` enabled cycles.
- R9: `load_i` has priority over `enable_i`. A load in the middle of a run discards the current run and starts the new seed.
- R10: Mask bit i controls output bit i, and 1 means acting. In the bench configuration (WIDTH=8), a seed of 8'h01 with mask 8'h81 in plain mode gives 8'h80 after one rotation and 8'h01 after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load seed, mask, mode and run length |
| seed_i | input | WIDTH | Seed pattern |
| act_mask_i | input | WIDTH | 1 = acting bit, 0 = frozen bit |
| twist_i | input | 1 | 0 = plain ring, 1 = inverted feedback at wrap |
| run_len_i | input | CNT_W | Number of rotations for this seed |
| enable_i | input | 1 | Advance one rotation this cycle |
| pattern_o | output | WIDTH | Pattern applied to the circuit under test |
| done_o | output | 1 | Run length reached |

## Verification
The bench builds the block with WIDTH=8 and CNT_W=6. With eight bits, masks with zero, one, two, scattered and contiguous acting bits can all be tried. With run lengths below 64, a run is long enough to wrap a ring several times and to keep enabling past done, yet each run stays a few dozen cycles. A zero run length and a reload in the middle of a run reach the edges of the counter. Twisted runs longer than twice the ring length show the inversion returning to the seed.

// File: rtl/vl_ring_pkg.sv
package vl_ring_pkg;
   typedef enum logic {
      RING_PLAIN = 1'b0,
      RING_TWIST = 1'b1
   } ring_mode_e;
endpackage

// File: rtl/vl_ring_rotate.sv
module vl_ring_rotate #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] pat_i,
   input  logic [WIDTH-1:0] mask_i,
   input  logic             invert_wrap_i,
   output logic [WIDTH-1:0] nxt_o,
   output logic             live_o
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("vl_ring_rotate: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] turned;
   logic             top_val;

   // ring is live only with two or more acting bits
   assign live_o = |(mask_i & (mask_i - WIDTH'(1)));

   // value held by the highest acting position
   always_comb begin
      top_val = 1'b0;
      for (int j = 0; j <= TOP; j++) begin
         if (mask_i[j]) top_val = pat_i[j];
      end
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic below_hit;
         logic below_val;
         always_comb begin
            below_hit = 1'b0;
            below_val = 1'b0;
            for (int j = 0; j < i; j++) begin
               if (mask_i[j]) begin
                  below_hit = 1'b1;
                  below_val = pat_i[j];
               end
            end
         end
         assign turned[i] = !mask_i[i] ? pat_i[i] :
                            below_hit  ? below_val :
                                         (top_val ^ invert_wrap_i);
      end
   endgenerate

   assign nxt_o = live_o ? turned : pat_i;
endmodule

// File: rtl/vl_ring_ctrl.sv
module vl_ring_ctrl #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             enable_i,
   output logic             step_o,
   output logic             done_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("vl_ring_ctrl: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_q;
   logic             armed_q;
   logic             at_end;

   assign at_end = (cnt_q == len_q);
   assign done_o = armed_q && at_end;
   assign step_o = enable_i && !load_i && armed_q && !at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         len_q   <= '0;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= '0;
         len_q   <= len_i;
         armed_q <= 1'b1;
      end else if (step_o) begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= len_q);

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !load_i |=> done_o);

   // R6
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !enable_i |=> $stable(cnt_q));
endmodule

// File: rtl/vl_ring_store.sv
module vl_ring_store #(
   parameter int WIDTH    = 16,
   parameter bit TWIST_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [WIDTH-1:0]       seed_i,
   input  logic [WIDTH-1:0]       mask_i,
   input  vl_ring_pkg::ring_mode_e mode_i,
   input  logic                   step_i,
   input  logic [WIDTH-1:0]       nxt_i,
   output logic [WIDTH-1:0]       pat_o,
   output logic [WIDTH-1:0]       mask_o,
   output logic                   invert_o
);
   import vl_ring_pkg::*;

   ring_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_o  <= '0;
         mask_o <= '0;
      end else if (load_i) begin
         pat_o  <= seed_i;
         mask_o <= mask_i;
      end else if (step_i) begin
         pat_o  <= nxt_i;
      end
   end

   generate
      if (TWIST_EN) begin : g_twist
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      mode_q <= RING_PLAIN;
            else if (load_i) mode_q <= mode_i;
         end
      end else begin : g_plain_only
         assign mode_q = RING_PLAIN;
      end
   endgenerate

   assign invert_o = (mode_q == RING_TWIST);

   // R2
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> pat_o == $past(seed_i));

   // R3
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ((pat_o & ~mask_o) == ($past(pat_o) & ~$past(mask_o))));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !step_i |=> $stable(pat_o));
endmodule

// File: rtl/vl_ring_tpg.sv
module vl_ring_tpg #(
   parameter int WIDTH    = 16,
   parameter int CNT_W    = 16,
   parameter bit TWIST_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   input  logic [WIDTH-1:0] act_mask_i,
   input  logic             twist_i,
   input  logic [CNT_W-1:0] run_len_i,
   input  logic             enable_i,
   output logic [WIDTH-1:0] pattern_o,
   output logic             done_o
);
   import vl_ring_pkg::*;

   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] mask_q;
   logic             invert;
   logic             live;
   logic             step;
   ring_mode_e       mode_in;

   assign mode_in = twist_i ? RING_TWIST : RING_PLAIN;

   vl_ring_ctrl #(.CNT_W(CNT_W)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .len_i    (run_len_i),
      .enable_i (enable_i),
      .step_o   (step),
      .done_o   (done_o)
   );

   vl_ring_store #(.WIDTH(WIDTH), .TWIST_EN(TWIST_EN)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .seed_i   (seed_i),
      .mask_i   (act_mask_i),
      .mode_i   (mode_in),
      .step_i   (step),
      .nxt_i    (nxt),
      .pat_o    (pattern_o),
      .mask_o   (mask_q),
      .invert_o (invert)
   );

   vl_ring_rotate #(.WIDTH(WIDTH)) i_rot (
      .pat_i         (pattern_o),
      .mask_i        (mask_q),
      .invert_wrap_i (invert),
      .nxt_o         (nxt),
      .live_o        (live)
   );

   // R4
   plain_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !invert |=>
         $countones(pattern_o & mask_q) == $past($countones(pattern_o & mask_q)));

   // R8
   dead_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !live |=> $stable(pattern_o));

   // R7
   done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !load_i |=> $stable(pattern_o));
endmodule

// File: tb/test_vl_ring_tpg.sv
module test_vl_ring_tpg;
   localparam int W = 8;
   localparam int C = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [W-1:0] seed_i = '0;
   logic [W-1:0] act_mask_i = '0;
   logic         twist_i = 1'b0;
   logic [C-1:0] run_len_i = '0;
   logic         enable_i = 1'b0;
   logic [W-1:0] pattern_o;
   logic         done_o;

   always #10ns clk = ~clk;

   vl_ring_tpg #(.WIDTH(W), .CNT_W(C), .TWIST_EN(1'b1)) i_vl_ring_tpg (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
      .act_mask_i(act_mask_i), .twist_i(twist_i), .run_len_i(run_len_i),
      .enable_i(enable_i), .pattern_o(pattern_o), .done_o(done_o));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [W-1:0] q_pat[$];
   logic         q_done[$];
   string        q_tag[$];

   // reference state
   logic [W-1:0] m_pat = '0, m_mask = '0;
   logic         m_tw = 1'b0, m_armed = 1'b0;
   int           m_len = 0, m_cnt = 0;

   function automatic logic [W-1:0] ref_rotate(logic [W-1:0] p, logic [W-1:0] m, logic tw);
      int idx[$];
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) if (m[i]) idx.push_back(i);
      if (idx.size() < 2) return p;
      r = p;
      for (int k = 0; k < idx.size(); k++) begin
         int src;
         src = (k == 0) ? idx[idx.size()-1] : idx[k-1];
         r[idx[k]] = p[src] ^ ((k == 0) ? tw : 1'b0);
      end
      return r;
   endfunction

   task automatic check(string tag, logic [W-1:0] got_p, logic got_d,
                        logic [W-1:0] exp_p, logic exp_d);
      checks++;
      if (got_p !== exp_p || got_d !== exp_d) begin
         errors++;
         $display("FAIL %s: pattern=%h done=%b expected pattern=%h done=%b",
                  tag, got_p, got_d, exp_p, exp_d);
      end
   endtask

   // driver: one cycle of stimulus, expected result queued for the next edge
   task automatic cyc(logic ld, logic [W-1:0] sd, logic [W-1:0] mk, logic tw,
                      int ln, logic en, string tag);
      @(negedge clk);
      load_i = ld; seed_i = sd; act_mask_i = mk; twist_i = tw;
      run_len_i = C'(ln); enable_i = en;
      if (ld) begin
         m_pat = sd; m_mask = mk; m_tw = tw; m_len = ln; m_cnt = 0; m_armed = 1'b1;
      end else if (en && m_armed && m_cnt != m_len) begin
         m_pat = ref_rotate(m_pat, m_mask, m_tw);
         m_cnt++;
      end
      q_pat.push_back(m_pat);
      q_done.push_back(m_armed && m_cnt == m_len);
      q_tag.push_back(tag);
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0, 0, 1'b1, tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0, 0, 1'b0, tag);
   endtask

   // monitor
   always @(posedge clk) begin
      #2ns;
      if (q_pat.size() > 0) begin
         logic [W-1:0] ep;
         logic ed;
         string tg;
         ep = q_pat.pop_front();
         ed = q_done.pop_front();
         tg = q_tag.pop_front();
         check(tg, pattern_o, done_o, ep, ed);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20ns * 100000);
      checks++; errors++;
      $display("FAIL watchdog: expired, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", pattern_o, done_o, '0, 1'b0);
      rst_n = 1'b1;
      idle(2, "R1 after reset");

      // plain ring over scattered acting bits, run past done
      cyc(1'b1, 8'hA6, 8'h5A, 1'b0, 5, 1'b0, "R2 load");
      run(3, "R4 plain rotate");
      idle(2, "R6 enable low");
      run(2, "R4 plain rotate");
      run(4, "R7 hold after done");

      // frozen bits on a contiguous high ring, twisted
      cyc(1'b1, 8'h3C, 8'hF0, 1'b1, 9, 1'b1, "R2 load twist");
      run(4, "R5 twist rotate");
      cyc(1'b0, '0, '0, 1'b0, 0, 1'b0, "R6 pause");
      run(7, "R3 R5 frozen with twist");

      // position mapping
      cyc(1'b1, 8'h01, 8'h81, 1'b0, 3, 1'b0, "R10 load");
      run(1, "R10 first rotation");
      run(1, "R10 second rotation");
      run(2, "R10 done");

      // short rings
      cyc(1'b1, 8'h5B, 8'h08, 1'b1, 4, 1'b1, "R8 single acting");
      run(6, "R8 single acting");
      cyc(1'b1, 8'hC3, 8'h00, 1'b0, 2, 1'b1, "R8 no acting");
      run(3, "R8 no acting");

      // zero run length
      cyc(1'b1, 8'h96, 8'hFF, 1'b0, 0, 1'b1, "R2 R7 zero length");
      run(2, "R7 zero length hold");

      // reload in the middle of a run
      cyc(1'b1, 8'h0F, 8'hFF, 1'b1, 20, 1'b0, "R2 load");
      run(5, "R5 full twist");
      cyc(1'b1, 8'h81, 8'h66, 1'b0, 3, 1'b1, "R9 reload mid run");
      run(5, "R9 new run");

      idle(2, "R6 tail");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule